// File: doc/BRIEF.md
# Reference Clock Quality Monitor

This block watches one incoming timing reference against a stable local clock. It passes the reference through a two-flop synchronizer and detects its edges. It then counts those edges over a fixed gate window of local-clock cycles. From the counts it decides which of four allowed nominal rates is present: 8 kHz, 1.544 MHz, 2.048 MHz or 19.44 MHz. It also grades how far the reference sits from that rate. A wide-limit deviation, or a reference that stops toggling, raises the holdover flag. The holdover flag in turn drives a request that forces the downstream timing core into automatic holdover. A narrow-limit deviation raises a frequency-limit flag, which marks the reference as outside the capture range.

A system uses two instances, one for the primary reference and one for the secondary reference. They run independently, and their status feeds the selector that picks which reference drives the downstream core. The expected edge count for each rate is a compile-time parameter. It is set from the gate length and the local clock rate. The two ppm limits and the loss timeout are also parameters. Every port carries plain control or status. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `ref_quality_monitor`

## Requirements
- R1: After reset, and until the first gate window ends, the outputs are `rate_code` = 00, `holdover` = 1, `freq_limit` = 1 and `holdover_req` = 1.
- R2: The rate codes are 00 = 8 kHz, 01 = 1.544 MHz, 10 = 2.048 MHz and 11 = 19.44 MHz. At the end of a window, the 19.44 MHz rate is identified from the rising-edge count. The other three rates are identified from the falling-edge count. A count identifies a rate when it lies within that rate's wide tolerance, which is floor(expected × WIDE_PPM / 1e6).
- R3: At the end of a window, if no rate matches, `holdover` and `freq_limit` are both set to 1.
- R4: At the end of a window, if a rate matches but the count differs from its expected count by more than floor(expected × NARROW_PPM / 1e6), then `freq_limit` = 1 and `holdover` = 0. Whenever `holdover` is 1, `freq_limit` is also 1.
- R5: Suppose no edge of the selected kind arrives for LOS_CYCLES local cycles. The selected kind is rising when the code is 11 and falling otherwise. Then `holdover` and `freq_limit` rise within LOS_CYCLES + 4 cycles of the last such edge, without waiting for the window to end.
- R6: `rate_code` changes only at the end of a window. Both flags also change only at the end of a window, except for the immediate set in R5.
- R7: A flag clears only at the end of a window that had no loss of reference and whose count matched within limits. A window that contained a loss keeps `holdover` at 1.
- R8: `holdover_req` equals `holdover` on every cycle.
- R9: A window that fails to match, or that contains a loss, leaves `rate_code` at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stable local clock that times the gate window and all state |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Timing reference, asynchronous to `clk` |
| rate_code | output | 2 | Identified nominal rate (encoding in R2) |
| holdover | output | 1 | Wide-limit or loss flag |
| freq_limit | output | 1 | Narrow-limit flag (outside the capture range) |
| holdover_req | output | 1 | Request forcing the downstream timing core into automatic holdover |

## Verification
The hardest situation to reach from the ports is recovery after a loss. Two things must be shown. A window that contains part of the outage must still report holdover. The flag must then clear exactly at the end of the next full clean window, and not sooner. The stimulus stops the reference on a low level just after a falling edge, so the loss latency can be bounded from the last edge. It then restarts the reference right after a window boundary, which the bench locates through its own behavioural window count. Separately, phase-offset reference periods are used to place counts just inside the wide limit and just outside the narrow limit.

// File: rtl/rcqm_pkg.sv
package rcqm_pkg;
  typedef enum logic [1:0] {
    RATE_8K = 2'b00,
    RATE_T1 = 2'b01,
    RATE_E1 = 2'b10,
    RATE_HI = 2'b11
  } rate_t;

  // Allowed count error for a given expected count and ppm limit (floored).
  function automatic int ppm_tol(int exp_cnt, int ppm);
    longint prod;
    prod = longint'(exp_cnt) * longint'(ppm);
    return int'(prod / 64'sd1000000);
  endfunction
endpackage

// File: rtl/rcqm_edge_sync.sv
module rcqm_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= ref_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/rcqm_window.sv
module rcqm_window #(
  parameter int GATE_CYCLES = 4096,
  localparam int WW = $clog2(GATE_CYCLES),
  localparam int CW = $clog2(GATE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          fall_i,
  output logic          win_end_o,
  output logic [CW-1:0] rise_tot_o,
  output logic [CW-1:0] fall_tot_o
);
  logic [WW-1:0] win_q;
  logic [1:0]    ev;
  logic [CW-1:0] tot [2];

  assign win_end_o = (win_q == WW'(GATE_CYCLES - 1));
  assign ev = {fall_i, rise_i};

  always_ff @(posedge clk) begin
    if (!rst_n)         win_q <= '0;
    else if (win_end_o) win_q <= '0;
    else                win_q <= win_q + 1'b1;
  end

  for (genvar g = 0; g < 2; g++) begin : g_tally
    logic [CW-1:0] acc_q;
    assign tot[g] = acc_q + CW'(ev[g]);
    always_ff @(posedge clk) begin
      if (!rst_n)         acc_q <= '0;
      else if (win_end_o) acc_q <= '0;
      else                acc_q <= tot[g];
    end
    // R2: a window can never hold more edges than it has cycles
    p_tally_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q <= CW'(GATE_CYCLES));
  end

  assign rise_tot_o = tot[0];
  assign fall_tot_o = tot[1];
endmodule

// File: rtl/rcqm_los_timer.sv
module rcqm_los_timer #(
  parameter int LOS_CYCLES = 1536,
  localparam int TW = $clog2(LOS_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic lost_o
);
  logic [TW-1:0] tmr_q;

  assign lost_o = (tmr_q == TW'(LOS_CYCLES));

  always_ff @(posedge clk) begin
    if (!rst_n)      tmr_q <= '0;
    else if (edge_i) tmr_q <= '0;
    else if (!lost_o) tmr_q <= tmr_q + 1'b1;
  end

  // R5: a selected edge always restarts the silence count
  p_edge_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> !lost_o);
endmodule

// File: rtl/rcqm_classify.sv
module rcqm_classify
  import rcqm_pkg::*;
#(
  parameter int CW         = 13,
  parameter int EXP_8K     = 4,
  parameter int EXP_T1     = 64,
  parameter int EXP_E1     = 128,
  parameter int EXP_HI     = 1024,
  parameter int NARROW_PPM = 104,
  parameter int WIDE_PPM   = 30000
) (
  input  logic [CW-1:0] rise_tot_i,
  input  logic [CW-1:0] fall_tot_i,
  output logic          match_o,
  output rate_t         code_o,
  output logic          narrow_ok_o
);
  localparam int EXP_F [3] = '{EXP_8K, EXP_T1, EXP_E1};
  localparam int HI_WT = ppm_tol(EXP_HI, WIDE_PPM);
  localparam int HI_NT = ppm_tol(EXP_HI, NARROW_PPM);

  logic [2:0] f_in, f_tight;
  logic       hi_in, hi_tight;
  logic signed [31:0] hi_dev;

  assign hi_dev   = $signed({{(32-CW){1'b0}}, rise_tot_i}) - EXP_HI;
  assign hi_in    = (hi_dev >= -HI_WT) && (hi_dev <= HI_WT);
  assign hi_tight = (hi_dev >= -HI_NT) && (hi_dev <= HI_NT);

  for (genvar g = 0; g < 3; g++) begin : g_fall
    localparam int WT = ppm_tol(EXP_F[g], WIDE_PPM);
    localparam int NT = ppm_tol(EXP_F[g], NARROW_PPM);
    logic signed [31:0] dev;
    assign dev        = $signed({{(32-CW){1'b0}}, fall_tot_i}) - EXP_F[g];
    assign f_in[g]    = (dev >= -WT) && (dev <= WT);
    assign f_tight[g] = (dev >= -NT) && (dev <= NT);
  end

  always_comb begin
    match_o     = 1'b0;
    code_o      = RATE_8K;
    narrow_ok_o = 1'b0;
    if (hi_in) begin
      match_o     = 1'b1;
      code_o      = RATE_HI;
      narrow_ok_o = hi_tight;
    end else begin
      for (int i = 2; i >= 0; i--) begin
        if (f_in[i]) begin
          match_o     = 1'b1;
          code_o      = rate_t'(2'(i));
          narrow_ok_o = f_tight[i];
        end
      end
    end
  end
endmodule

// File: rtl/ref_quality_monitor.sv
module ref_quality_monitor
  import rcqm_pkg::*;
#(
  parameter int GATE_CYCLES = 4096,
  parameter int LOS_CYCLES  = 1536,
  parameter int EXP_8K      = 4,
  parameter int EXP_T1      = 64,
  parameter int EXP_E1      = 128,
  parameter int EXP_HI      = 1024,
  parameter int NARROW_PPM  = 104,
  parameter int WIDE_PPM    = 30000,
  localparam int CW = $clog2(GATE_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  output logic [1:0] rate_code,
  output logic       holdover,
  output logic       freq_limit,
  output logic       holdover_req
);
  logic          rise, fall, sel_edge, lost, win_end;
  logic [CW-1:0] rise_tot, fall_tot;
  logic          match, narrow_ok, loss_seen_q, win_bad;
  rate_t         code, rate_q;

  rcqm_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ref_async(ref_in),
    .rise_o(rise), .fall_o(fall)
  );

  rcqm_window #(.GATE_CYCLES(GATE_CYCLES)) u_win (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
    .win_end_o(win_end), .rise_tot_o(rise_tot), .fall_tot_o(fall_tot)
  );

  // Timing edge follows the identified rate: rising only for the fast rate.
  assign sel_edge = (rate_q == RATE_HI) ? rise : fall;

  rcqm_los_timer #(.LOS_CYCLES(LOS_CYCLES)) u_los (
    .clk(clk), .rst_n(rst_n), .edge_i(sel_edge), .lost_o(lost)
  );

  rcqm_classify #(
    .CW(CW), .EXP_8K(EXP_8K), .EXP_T1(EXP_T1), .EXP_E1(EXP_E1),
    .EXP_HI(EXP_HI), .NARROW_PPM(NARROW_PPM), .WIDE_PPM(WIDE_PPM)
  ) u_cls (
    .rise_tot_i(rise_tot), .fall_tot_i(fall_tot),
    .match_o(match), .code_o(code), .narrow_ok_o(narrow_ok)
  );

  assign win_bad = loss_seen_q | lost;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q      <= RATE_8K;
      holdover    <= 1'b1;
      freq_limit  <= 1'b1;
      loss_seen_q <= 1'b0;
    end else if (win_end) begin
      holdover    <= ~match | win_bad;
      freq_limit  <= ~match | win_bad | ~narrow_ok;
      if (match && !win_bad) rate_q <= code;
      loss_seen_q <= 1'b0;
    end else if (lost) begin
      holdover    <= 1'b1;
      freq_limit  <= 1'b1;
      loss_seen_q <= 1'b1;
    end
  end

  assign rate_code    = rate_q;
  assign holdover_req = holdover;

  // R4: the wide flag never stands without the narrow one
  p_hold_implies_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    holdover |-> freq_limit);
  // R6: the code only moves on a window boundary
  p_code_at_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(rate_code));
  // R7: the flags only clear on a window boundary
  p_hold_clear_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holdover) |-> $past(win_end));
  p_limit_clear_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freq_limit) |-> $past(win_end));
  // R5: silence forces holdover on the next cycle
  p_loss_forces_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> holdover);
  // R9: a window ending in loss keeps the code
  p_loss_keeps_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && win_bad) |=> $stable(rate_code));
endmodule

// File: tb/tb_ref_quality_monitor.sv
`timescale 1ns/10ps
module tb_ref_quality_monitor;
  localparam real CLK_PERIOD = 10.0;
  localparam int  GATE = 4096;
  localparam int  LOS  = 1536;
  localparam int  WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic [1:0] rate_code;
  logic holdover, freq_limit, holdover_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  ref_quality_monitor dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rate_code(rate_code),
    .holdover(holdover), .freq_limit(freq_limit), .holdover_req(holdover_req)
  );

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  // Reference generator: toggle times keep a 0.05 ns offset, never on a clock edge.
  real half_ns = 320.0;
  bit  run = 1'b0;
  bit  stop_req = 1'b0;
  initial begin
    #2.05;
    forever begin
      if (run) begin
        #(half_ns) ref_in = ~ref_in;
        if (stop_req && !ref_in) begin
          run = 1'b0;
          stop_req = 1'b0;
        end
      end else begin
        #10;
      end
    end
  end

  // Behavioural model from the requirements.
  int m_exp [4] = '{4, 64, 128, 1024};
  int m_wt [4];
  int m_nt [4];
  bit m_hist [$];
  int m_wcnt, m_rc, m_fc, m_silent, m_code;
  bit m_hold, m_lim, m_loss_win;

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_wt[i] = int'((longint'(m_exp[i]) * 30000) / 1000000);
      m_nt[i] = int'((longint'(m_exp[i]) * 104) / 1000000);
    end
  end

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  always @(posedge clk) begin
    bit up, dn, sel, gone, ok, tight;
    int rc, fc, code;
    cyc++;
    if (!rst_n) begin
      m_hist = '{1'b0, 1'b0, 1'b0};
      m_wcnt = 0; m_rc = 0; m_fc = 0; m_silent = 0; m_code = 0;
      m_hold = 1'b1; m_lim = 1'b1; m_loss_win = 1'b0;
    end else begin
      up = m_hist[1] && !m_hist[2];
      dn = !m_hist[1] && m_hist[2];
      m_hist.push_front(ref_in);
      void'(m_hist.pop_back());
      sel = (m_code == 3) ? up : dn;
      gone = (m_silent >= LOS);
      if (sel) m_silent = 0;
      else if (m_silent < LOS) m_silent++;
      if (m_wcnt == GATE - 1) begin
        rc = m_rc + int'(up);
        fc = m_fc + int'(dn);
        ok = 1'b0; tight = 1'b0; code = 0;
        if (absd(rc, m_exp[3]) <= m_wt[3]) begin
          ok = 1'b1; code = 3; tight = absd(rc, m_exp[3]) <= m_nt[3];
        end else begin
          for (int i = 2; i >= 0; i--)
            if (absd(fc, m_exp[i]) <= m_wt[i]) begin
              ok = 1'b1; code = i; tight = absd(fc, m_exp[i]) <= m_nt[i];
            end
        end
        m_hold = !ok || m_loss_win || gone;
        m_lim  = m_hold || !tight;
        if (ok && !(m_loss_win || gone)) m_code = code;
        m_loss_win = 1'b0;
        m_rc = 0; m_fc = 0; m_wcnt = 0;
      end else begin
        if (gone) begin
          m_hold = 1'b1; m_lim = 1'b1; m_loss_win = 1'b1;
        end
        m_rc += int'(up);
        m_fc += int'(dn);
        m_wcnt++;
      end
    end
  end

  // Every-cycle comparison: R6 timing of updates, R8 request mirror.
  always @(negedge clk) begin
    if (rst_n && cyc > 1) begin
      total++;
      if (rate_code !== 2'(m_code) || holdover !== m_hold ||
          freq_limit !== m_lim || holdover_req !== m_hold) begin
        bad++;
        $display("FAIL R6 R8 cycle %0d: got code=%0d hold=%b lim=%b req=%b exp code=%0d hold=%b lim=%b req=%b",
                 cyc, rate_code, holdover, freq_limit, holdover_req, m_code, m_hold, m_lim, m_hold);
      end
    end
  end

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic next_window();
    do @(negedge clk); while (m_wcnt != 0);
  endtask

  task automatic windows(int n);
    for (int i = 0; i < n; i++) next_window();
  endtask

  task automatic flags(string req, int code, bit h, bit l);
    chk({req, " code"}, int'(rate_code), code);
    chk({req, " holdover"}, int'(holdover), int'(h));
    chk({req, " freq_limit"}, int'(freq_limit), int'(l));
    chk({req, " request"}, int'(holdover_req), int'(h));
  endtask

  initial begin
    int lat;
    repeat (10) @(negedge clk);
    flags("R1 reset", 0, 1'b1, 1'b1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    flags("R1 before first window", 0, 1'b1, 1'b1);

    half_ns = 320.0; run = 1'b1;
    windows(3);
    flags("R2 1.544 MHz", 1, 1'b0, 1'b0);

    half_ns = 20.0;
    windows(2);
    flags("R2 19.44 MHz rising edges", 3, 1'b0, 1'b0);

    half_ns = 20.1;
    windows(2);
    flags("R4 narrow offset fast rate", 3, 1'b0, 1'b1);

    half_ns = 23.0;
    windows(2);
    flags("R3 R9 wide offset keeps code", 3, 1'b1, 1'b1);

    half_ns = 160.0;
    windows(2);
    flags("R2 2.048 MHz", 2, 1'b0, 1'b0);

    half_ns = 157.5;
    windows(2);
    flags("R4 narrow offset 2.048", 2, 1'b0, 1'b1);

    half_ns = 5120.0;
    windows(3);
    flags("R2 8 kHz", 0, 1'b0, 1'b0);

    // Loss: stop just after a falling edge, measure the latency.
    stop_req = 1'b1;
    wait (run == 1'b0);
    lat = 0;
    while (holdover == 1'b0 && lat < LOS + 20) begin
      @(negedge clk);
      lat++;
    end
    total++;
    if (lat < LOS - 2 || lat > LOS + 4) begin
      bad++;
      $display("FAIL R5 loss latency: got %0d exp %0d..%0d", lat, LOS - 2, LOS + 4);
    end
    chk("R5 limit on loss", int'(freq_limit), 1);
    next_window();
    flags("R9 code held through loss", 0, 1'b1, 1'b1);

    // Recovery right after a boundary: window with loss stays bad, next clears.
    half_ns = 320.0; run = 1'b1;
    next_window();
    flags("R7 window with loss", 0, 1'b1, 1'b1);
    next_window();
    flags("R7 clean window clears", 1, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule